// File: doc/BRIEF.md
# Streaming Maximum-Extraction Sorter

This block sorts a short list of unsigned values into descending order while the list is still arriving. Values enter one beat at a time on a valid-qualified input. The final value of each list carries a last flag, which closes the list. Inside, a chain of identical cells runs in series. Each cell keeps the largest value it has seen in the current list and passes every other value to the next cell. Cell 0 therefore holds the list maximum, cell 1 the maximum of what remains, and so on. When the closing beat reaches a cell, the cell releases its kept value. Because the closing beat moves down the chain one cell per cycle, the released values come out one per cycle, largest first.

The output is a valid-qualified stream with a last flag on the smallest value of each list. Neither side has a stall signal. A list may hold from one value up to the number of cells. Valid beats inside a list may be separated by idle cycles. The next list may begin on the cycle after the previous closing beat, provided its own closing beat keeps the spacing stated in R8.

Top module: `maxpipe_sorter`

## Requirements
- R1: While the core reset is active, and on the first cycles after it is released, `out_valid` is low.
- R2: For a list of L values (1 ≤ L ≤ CELLS), exactly L results are produced. Each result is one of the input values, and together they appear in non-increasing order.
- R3: If the closing beat of a list is captured at clock edge P, result k (k = 0 for the largest) is valid after edge P+2+k. The results of one list therefore occupy consecutive cycles.
- R4: `out_last` is 1 only on result L-1 of each list, and 0 on every other result.
- R5: Repeated values are all kept. A value that occurs n times in the list occurs n times in the output.
- R6: A list of one value produces that value, with `out_last` = 1, two cycles after its closing beat.
- R7: Idle input cycles (`in_valid` = 0) inside a list change neither the result values nor their timing. Timing is measured from the closing beat.
- R8: A new list may start on any cycle after the previous closing beat. Its closing beat must come at least L_prev cycles after the previous one. Under that rule, each list's results are complete, in order, and never overlap another list's results.
- R9: `out_valid` is low on every cycle that R3 does not assign to a result.
- R10: Comparison is unsigned over the full width, so all-ones ranks highest and zero ranks lowest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| in_valid | input | 1 | Input beat present |
| in_data | input | WIDTH | Input value, unsigned |
| in_last | input | 1 | Marks the closing beat of a list; qualified by in_valid |
| out_valid | output | 1 | Result present |
| out_data | output | WIDTH | Result value |
| out_last | output | 1 | Marks the smallest result of a list |

## Verification
Every result has a fixed due cycle. Result k of a list is due two cycles after the clock edge that captures the list's closing beat, plus k, whatever idle cycles came before that beat. When the bench drives a closing beat, it writes the expected value, last flag and requirement tag into a table indexed by that due cycle. On every falling edge it compares the outputs with the table entry for the current cycle, and it requires `out_valid` to be low wherever the table is empty. The stream driver holds back each closing beat until the R8 spacing is met, so results from neighbouring lists never compete for the same cycle.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
  localparam int MXS_CELLS_DEF = 8;
  localparam int MXS_WIDTH_DEF = 16;

  // Per-beat decision taken by a full sorting cell.
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_LOAD,    // first value of a list: keep it
    ACT_KEEP,    // not larger: pass the arriving value on
    ACT_SWAP,    // larger: pass the old kept value on, keep the new one
    ACT_SOLO,    // closing beat with nothing kept: release it as the final result
    ACT_FINISH   // closing beat: release the larger, pass the smaller on with last
  } cell_act_e;
endpackage

// File: rtl/mxs_rst_sync.sv
module mxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mxs_cell.sv
module mxs_cell
  import mxs_pkg::*;
#(
  parameter int WIDTH = MXS_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             up_v,
  input  logic [WIDTH-1:0] up_d,
  input  logic             up_l,
  output logic             dn_v,
  output logic [WIDTH-1:0] dn_d,
  output logic             dn_l,
  output logic             res_v,
  output logic [WIDTH-1:0] res_d,
  output logic             res_l
);
  cell_act_e        act;
  logic             held_q, held_n;
  logic [WIDTH-1:0] acc_q, acc_n;
  logic             acc_en;
  logic             bigger;
  logic             dn_v_n, dn_l_n, res_v_n, res_l_n;
  logic [WIDTH-1:0] dn_d_n, res_d_n;

  assign bigger = up_d > acc_q;

  // Decide what this beat does.
  always_comb begin
    act = ACT_IDLE;
    if (up_v) begin
      if (!held_q)   act = up_l ? ACT_SOLO : ACT_LOAD;
      else if (up_l) act = ACT_FINISH;
      else           act = bigger ? ACT_SWAP : ACT_KEEP;
    end
  end

  // Next state.
  always_comb begin
    held_n  = held_q;
    acc_n   = acc_q;
    acc_en  = 1'b0;
    dn_v_n  = 1'b0;
    dn_d_n  = up_d;
    dn_l_n  = 1'b0;
    res_v_n = 1'b0;
    res_d_n = up_d;
    res_l_n = 1'b0;
    unique case (act)
      ACT_LOAD: begin
        held_n = 1'b1;
        acc_n  = up_d;
        acc_en = 1'b1;
      end
      ACT_KEEP: dn_v_n = 1'b1;
      ACT_SWAP: begin
        dn_v_n = 1'b1;
        dn_d_n = acc_q;
        acc_n  = up_d;
        acc_en = 1'b1;
      end
      ACT_SOLO: begin
        res_v_n = 1'b1;
        res_l_n = 1'b1;
      end
      ACT_FINISH: begin
        held_n  = 1'b0;
        dn_v_n  = 1'b1;
        dn_l_n  = 1'b1;
        res_v_n = 1'b1;
        if (bigger) dn_d_n  = acc_q;
        else        res_d_n = acc_q;
      end
      default: ;
    endcase
  end

  // Control registers, asynchronous reset.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      held_q <= 1'b0;
      dn_v   <= 1'b0;
      dn_l   <= 1'b0;
      res_v  <= 1'b0;
      res_l  <= 1'b0;
    end else begin
      held_q <= held_n;
      dn_v   <= dn_v_n;
      dn_l   <= dn_l_n;
      res_v  <= res_v_n;
      res_l  <= res_l_n;
    end
  end

  // Data registers, loaded only under their enables.
  always_ff @(posedge clk) begin
    if (acc_en)  acc_q <= acc_n;
    if (dn_v_n)  dn_d  <= dn_d_n;
    if (res_v_n) res_d <= res_d_n;
  end
endmodule

// File: rtl/mxs_tail.sv
module mxs_tail #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             up_v,
  input  logic [WIDTH-1:0] up_d,
  input  logic             up_l,
  output logic             res_v,
  output logic [WIDTH-1:0] res_d,
  output logic             res_l
);
  // In legal use, the last position only ever sees a single closing beat.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      res_v <= 1'b0;
      res_l <= 1'b0;
    end else begin
      res_v <= up_v;
      res_l <= up_v & up_l;
    end
  end

  always_ff @(posedge clk) begin
    if (up_v) res_d <= up_d;
  end
endmodule

// File: rtl/mxs_collect.sv
module mxs_collect #(
  parameter int CELLS = 8,
  parameter int WIDTH = 16
) (
  input  logic                        clk,
  input  logic                        arst_n,
  input  logic [CELLS-1:0]            hit_v,
  input  logic [CELLS-1:0][WIDTH-1:0] hit_d,
  input  logic [CELLS-1:0]            hit_l,
  output logic                        o_v,
  output logic [WIDTH-1:0]            o_d,
  output logic                        o_l
);
  logic [WIDTH-1:0] sel_d;
  logic             sel_l;
  logic             any_v;

  assign any_v = |hit_v;

  // Under the spacing rule at most one cell releases per cycle, so an AND-OR merge is enough.
  always_comb begin
    sel_d = '0;
    sel_l = 1'b0;
    for (int k = 0; k < CELLS; k++) begin
      if (hit_v[k]) begin
        sel_d = sel_d | hit_d[k];
        sel_l = sel_l | hit_l[k];
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      o_v <= 1'b0;
      o_l <= 1'b0;
    end else begin
      o_v <= any_v;
      o_l <= any_v & sel_l;
    end
  end

  always_ff @(posedge clk) begin
    if (any_v) o_d <= sel_d;
  end
endmodule

// File: rtl/maxpipe_sorter.sv
module maxpipe_sorter
  import mxs_pkg::*;
#(
  parameter int CELLS = MXS_CELLS_DEF,
  parameter int WIDTH = MXS_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_last,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             out_last
);
  localparam int LAST_CELL = CELLS - 1;

  logic                        core_rst_n;
  logic [CELLS-1:0]            lnk_v, lnk_l;
  logic [CELLS-1:0][WIDTH-1:0] lnk_d;
  logic [CELLS-1:0]            emit_v, emit_l;
  logic [CELLS-1:0][WIDTH-1:0] emit_d;

  mxs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  assign lnk_v[0] = in_valid;
  assign lnk_d[0] = in_data;
  assign lnk_l[0] = in_last;

  for (genvar k = 0; k < CELLS; k++) begin : g_pos
    if (k == LAST_CELL) begin : g_tail
      mxs_tail #(.WIDTH(WIDTH)) u_tail (
        .clk    (clk),
        .arst_n (core_rst_n),
        .up_v   (lnk_v[k]),
        .up_d   (lnk_d[k]),
        .up_l   (lnk_l[k]),
        .res_v  (emit_v[k]),
        .res_d  (emit_d[k]),
        .res_l  (emit_l[k])
      );
    end else begin : g_full
      mxs_cell #(.WIDTH(WIDTH)) u_cell (
        .clk    (clk),
        .arst_n (core_rst_n),
        .up_v   (lnk_v[k]),
        .up_d   (lnk_d[k]),
        .up_l   (lnk_l[k]),
        .dn_v   (lnk_v[k+1]),
        .dn_d   (lnk_d[k+1]),
        .dn_l   (lnk_l[k+1]),
        .res_v  (emit_v[k]),
        .res_d  (emit_d[k]),
        .res_l  (emit_l[k])
      );
    end
  end

  mxs_collect #(.CELLS(CELLS), .WIDTH(WIDTH)) u_collect (
    .clk    (clk),
    .arst_n (core_rst_n),
    .hit_v  (emit_v),
    .hit_d  (emit_d),
    .hit_l  (emit_l),
    .o_v    (out_valid),
    .o_d    (out_data),
    .o_l    (out_last)
  );
endmodule

// File: rtl/mxs_checker.sv
module mxs_checker #(
  parameter int CELLS = 8,
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_data,
  input logic             out_last,
  input logic [CELLS-1:0] emit_v,
  input logic             tail_v,
  input logic             tail_l
);
  // R1: nothing leaves while the core is held in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> !out_valid);

  // R3: the first result of a list follows its closing beat after two edges
  a_r3_first_result_latency: assert property (@(posedge clk) disable iff (!core_rst_n)
    (in_valid && in_last) |-> ##2 out_valid);

  // R2: results within one list never increase
  a_r2_nonincreasing: assert property (@(posedge clk) disable iff (!core_rst_n)
    (out_valid && !out_last) |=> (out_valid && (out_data <= $past(out_data))));

  // R4: the last flag only rides on a valid result
  a_r4_last_qualified: assert property (@(posedge clk) disable iff (!core_rst_n)
    out_last |-> out_valid);

  // R8: under the spacing rule at most one position releases per cycle
  a_r8_single_emitter: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0(emit_v));

  // R2: with L <= CELLS the final position only ever sees a closing beat
  a_r2_tail_single: assert property (@(posedge clk) disable iff (!core_rst_n)
    tail_v |-> tail_l);
endmodule

bind maxpipe_sorter mxs_checker #(.CELLS(CELLS), .WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .in_valid   (in_valid),
  .in_last    (in_last),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_last   (out_last),
  .emit_v     (emit_v),
  .tail_v     (lnk_v[CELLS-1]),
  .tail_l     (lnk_l[CELLS-1])
);

// File: tb/tb_maxpipe_sorter.sv
module tb_maxpipe_sorter;
  localparam int CELLS      = 8;
  localparam int WIDTH      = 16;
  localparam int CLK_PERIOD = 10;
  localparam int HORIZON    = 16384;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [WIDTH-1:0] in_data;
  logic             in_last;
  logic             out_valid;
  logic [WIDTH-1:0] out_data;
  logic             out_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  maxpipe_sorter #(.CELLS(CELLS), .WIDTH(WIDTH)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  int edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  logic             exp_v   [HORIZON];
  logic [WIDTH-1:0] exp_d   [HORIZON];
  logic             exp_l   [HORIZON];
  string            exp_tag [HORIZON];
  logic [WIDTH-1:0] vals    [CELLS];

  int total = 0;
  int bad   = 0;
  int prev_mark = -1000;
  int prev_len  = 0;
  bit finished  = 0;

  // R9 on empty cycles; otherwise the scheduled result (R2 R3 R4 and the tag's own requirement).
  task automatic check_cycle();
    int i;
    i = edge_n;
    if (i >= HORIZON) return;
    total++;
    if (exp_v[i]) begin
      if (out_valid !== 1'b1 || out_data !== exp_d[i] || out_last !== exp_l[i]) begin
        bad++;
        $display("FAIL %s cycle %0d: got v=%b d=%0d l=%b, expected v=1 d=%0d l=%b",
                 exp_tag[i], i, out_valid, out_data, out_last, exp_d[i], exp_l[i]);
      end
    end else if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R9 cycle %0d: got v=%b, expected v=0", i, out_valid);
    end
  endtask

  task automatic step(input logic v, input logic [WIDTH-1:0] d, input logic l);
    @(negedge clk);
    check_cycle();
    in_valid = v;
    in_data  = d;
    in_last  = l;
  endtask

  // Reference: a descending copy of the first len entries of vals.
  function automatic void ref_sort(input int len, output logic [WIDTH-1:0] s [CELLS]);
    logic [WIDTH-1:0] t;
    for (int i = 0; i < CELLS; i++) s[i] = vals[i];
    for (int i = 1; i < len; i++) begin
      for (int j = i; j > 0; j--) begin
        if (s[j] > s[j-1]) begin
          t = s[j]; s[j] = s[j-1]; s[j-1] = t;
        end
      end
    end
  endfunction

  task automatic send(input int len, input int idle_pct, input string tag);
    int mark;
    logic [WIDTH-1:0] srt [CELLS];
    mark = 0;
    for (int i = 0; i < len; i++) begin
      if (idle_pct > 0) begin
        while ($urandom_range(99) < idle_pct) step(1'b0, '0, 1'b0);
      end
      if (i == len - 1) begin
        while (edge_n + 1 - prev_mark < prev_len) step(1'b0, '0, 1'b0);
      end
      step(1'b1, vals[i], i == len - 1);
      if (i == len - 1) mark = edge_n;
    end
    ref_sort(len, srt);
    for (int k = 0; k < len; k++) begin
      if (mark + 2 + k < HORIZON) begin
        exp_v[mark+2+k]   = 1'b1;
        exp_d[mark+2+k]   = srt[k];
        exp_l[mark+2+k]   = (k == len - 1);
        exp_tag[mark+2+k] = tag;
      end
    end
    prev_mark = mark;
    prev_len  = len;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: got cycles=200000, expected completion earlier");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len;
    void'($urandom(32'd5150));
    for (int i = 0; i < HORIZON; i++) begin
      exp_v[i] = 1'b0; exp_d[i] = '0; exp_l[i] = 1'b0; exp_tag[i] = "";
    end
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;

    // R1: held in reset, outputs quiet
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin
        bad++;
        $display("FAIL R1 during reset: got v=%b, expected v=0", out_valid);
      end
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin
        bad++;
        $display("FAIL R1 after release: got v=%b, expected v=0", out_valid);
      end
    end
    idle(3);

    // R6: single value
    vals[0] = 16'd1234;
    send(1, 0, "R6");
    idle(4);

    // R2: ascending and descending full-length lists
    for (int i = 0; i < CELLS; i++) vals[i] = WIDTH'(i * 100 + 5);
    send(CELLS, 0, "R2 ascending");
    for (int i = 0; i < CELLS; i++) vals[i] = WIDTH'(900 - i * 100);
    send(CELLS, 0, "R2 descending");
    idle(CELLS + 3);

    // R5: repeated values
    for (int i = 0; i < 5; i++) vals[i] = 16'd7;
    send(5, 0, "R5 all equal");
    vals[0] = 3; vals[1] = 9; vals[2] = 3; vals[3] = 9; vals[4] = 1; vals[5] = 9;
    send(6, 0, "R5 mixed repeats");
    idle(CELLS);

    // R10: full-range unsigned extremes
    vals[0] = 16'h0000; vals[1] = 16'hFFFF; vals[2] = 16'h0001;
    vals[3] = 16'h8000; vals[4] = 16'h7FFF; vals[5] = 16'hFFFE;
    send(6, 0, "R10");
    idle(CELLS);

    // R7: idle cycles inside a list
    for (int i = 0; i < CELLS; i++) vals[i] = WIDTH'($urandom_range(500));
    send(CELLS, 50, "R7");
    idle(CELLS);

    // R8: back-to-back lists at the minimum legal spacing
    vals[0] = 40; vals[1] = 10; vals[2] = 30;
    send(3, 0, "R8 short then long");
    vals[0] = 2; vals[1] = 50; vals[2] = 8; vals[3] = 50; vals[4] = 1;
    send(5, 0, "R8 short then long");
    for (int i = 0; i < CELLS; i++) vals[i] = WIDTH'(i * 3 + 1);
    send(CELLS, 0, "R8 long then single");
    vals[0] = 16'd77;
    send(1, 0, "R8 long then single");
    for (int i = 0; i < 5; i++) vals[i] = WIDTH'($urandom_range(60));
    send(5, 0, "R8 equal lengths");
    for (int i = 0; i < 5; i++) vals[i] = WIDTH'($urandom_range(60));
    send(5, 0, "R8 equal lengths");
    idle(CELLS + 3);

    // Random lists, checked for order, count, timing and last flag
    for (int s = 0; s < 250; s++) begin
      len = $urandom_range(CELLS, 1);
      for (int i = 0; i < CELLS; i++) begin
        if (s % 3 == 0) vals[i] = WIDTH'($urandom_range(3));
        else            vals[i] = WIDTH'($urandom);
      end
      idle($urandom_range(2));
      send(len, (s % 4 == 1) ? 20 : 0, "R2 R3 R4 random");
    end
    idle(2 * CELLS + 4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule